// File: doc/BRIEF.md
# Port Pin Change Detector

This block watches the upper pins of a general-purpose I/O port and raises a sticky change flag when one of them no longer matches a reference snapshot. The snapshot is refreshed whenever software accesses the port, either by reading it or by writing it. The flag goes to the interrupt controller, and it can also serve as a request to wake the device from a sleep state. Enable, priority and sleep control live elsewhere. The port data, direction and latch registers also live elsewhere. This block only takes already-synchronized pin values, the direction bits and three single-cycle strobes from the register interface.

Only pins configured as inputs take part in the comparison. A pin driven as an output is masked. The lower pins of the port are never compared. While a mismatch exists, the flag is forced high again on every cycle, so software cannot silence it by clearing it. Software must first access the port so that the reference is reloaded; a clear sent after that access then sticks. The comparison is suppressed in the cycle of the access itself, so reading the port never produces a spurious flag.

Top module: `pin_change_detector`

## Requirements
- R1: A synchronous active-high reset clears the flag and loads the reference from the current pin values. If the pins are held unchanged after reset, the flag stays 0.
- R2: A watched pin is one of pins 7 to 4. If a watched input pin differs from its reference bit in a cycle with no port access, the flag is 1 after the next rising clock edge.
- R3: Pins 3 to 0 never affect the flag, whatever their values and direction bits.
- R4: A direction bit of 0 makes the pin an output, and that pin is excluded from the comparison. A direction bit of 1 makes the pin an input, and it takes part.
- R5: When a mismatch is present, setting the flag has priority over a clear strobe in the same cycle. The flag stays 1.
- R6: A read strobe loads the reference from the pins at that edge. A clear strobe on a later cycle then leaves the flag at 0.
- R7: A write strobe reloads the reference in the same way as a read strobe.
- R8: In a cycle with a read or write strobe, no mismatch can set the flag. The flag keeps its previous value unless a clear is also given.
- R9: Once set, the flag stays 1 even after the pins return to the reference value, until a clear strobe arrives.
- R10: A clear strobe in a cycle without an effective mismatch makes the flag 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | PORT_W | Synchronized port pin values |
| dir_i | input | PORT_W | Direction bits, 1 = input, 0 = output |
| rd_stb_i | input | 1 | Port read strobe, one cycle |
| wr_stb_i | input | 1 | Port write strobe, one cycle |
| clr_stb_i | input | 1 | Flag clear strobe, one cycle |
| chg_flag_o | output | 1 | Registered change flag, also the interrupt or wake request |

## Verification
Every result of this block appears one clock edge after the cycle that causes it:
- A mismatch, clear or reset shows on the flag after the next rising edge.
- A reference reload becomes visible through the flag one edge after the strobe.

The bench applies each stimulus at a falling edge and samples the flag 1 ns after the following rising edge. Each check therefore sees exactly the one edge the requirement speaks of. The sweep runs through all reference, pin and direction values of the watched nibble. It computes the expected flag as the OR of (pin XOR reference) AND direction.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int unsigned PCD_PORT_W   = 8;
  localparam int unsigned PCD_WATCH_LO = 4;

  typedef enum logic [1:0] {
    FLAG_HOLD  = 2'd0,
    FLAG_SET   = 2'd1,
    FLAG_CLEAR = 2'd2
  } flag_act_e;
endpackage

// File: rtl/pcd_lane.sv
module pcd_lane #(
  parameter logic WATCHED = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic dir_i,
  input  logic load_i,
  output logic mis_o
);
  logic ref_q;

  // Reference bit: reloaded on reset and on every port access
  always_ff @(posedge clk) begin
    if (rst || load_i) ref_q <= pin_i;
  end

  // Mismatch only for watched, input-configured lanes
  assign mis_o = WATCHED & dir_i & (pin_i ^ ref_q);

  AST_REF_LOAD: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (ref_q == $past(pin_i))); // R6
  AST_REF_KEEP: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(ref_q)); // R6
endmodule

// File: rtl/pcd_flag.sv
module pcd_flag
  import pcd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mis_any_i,
  input  logic access_i,
  input  logic clr_i,
  output logic flag_o
);
  flag_act_e act;
  logic      flag_q;

  // Set wins over clear; the comparison is blanked during an access
  always_comb begin
    if (mis_any_i && !access_i) act = FLAG_SET;
    else if (clr_i)             act = FLAG_CLEAR;
    else                        act = FLAG_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else begin
      case (act)
        FLAG_SET:   flag_q <= 1'b1;
        FLAG_CLEAR: flag_q <= 1'b0;
        default:    flag_q <= flag_q;
      endcase
    end
  end

  assign flag_o = flag_q;

  AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !flag_q); // R1
  AST_SET_ON_MIS: assert property (@(posedge clk) disable iff (rst)
    (mis_any_i && !access_i) |=> flag_q); // R2
  AST_SET_OVER_CLR: assert property (@(posedge clk) disable iff (rst)
    (mis_any_i && !access_i && clr_i) |=> flag_q); // R5
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    (access_i && !clr_i) |=> $stable(flag_q)); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_i) |=> flag_q); // R9
  AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !(mis_any_i && !access_i)) |=> !flag_q); // R10
endmodule

// File: rtl/pin_change_detector.sv
module pin_change_detector
  import pcd_pkg::*;
#(
  parameter int unsigned PORT_W   = PCD_PORT_W,
  parameter int unsigned WATCH_LO = PCD_WATCH_LO
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] pin_i,
  input  logic [PORT_W-1:0] dir_i,
  input  logic              rd_stb_i,
  input  logic              wr_stb_i,
  input  logic              clr_stb_i,
  output logic              chg_flag_o
);
  localparam int unsigned WATCH_N = PORT_W - WATCH_LO;

  logic [PORT_W-1:0] mis;
  logic              access;
  logic              mis_any;

  assign access  = rd_stb_i | wr_stb_i;
  assign mis_any = |mis;

  for (genvar i = 0; i < PORT_W; i++) begin : g_lane
    pcd_lane #(
      .WATCHED(i >= WATCH_LO)
    ) u_lane (
      .clk    (clk),
      .rst    (rst),
      .pin_i  (pin_i[i]),
      .dir_i  (dir_i[i]),
      .load_i (access),
      .mis_o  (mis[i])
    );
  end

  pcd_flag u_flag (
    .clk       (clk),
    .rst       (rst),
    .mis_any_i (mis_any),
    .access_i  (access),
    .clr_i     (clr_stb_i),
    .flag_o    (chg_flag_o)
  );

  AST_OUT_EXCLUDED: assert property (@(posedge clk) disable iff (rst)
    (!chg_flag_o && (dir_i[PORT_W-1 -: WATCH_N] == '0)) |=> !chg_flag_o); // R4
  AST_LOW_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mis[WATCH_LO-1:0] == '0)); // R3
endmodule

// File: tb/pin_change_detector_test.sv
`timescale 1ns/1ps
module pin_change_detector_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pin = 8'h00;
  logic [7:0] dir = 8'hFF;
  logic       rd_stb = 1'b0;
  logic       wr_stb = 1'b0;
  logic       clr_stb = 1'b0;
  logic       flag;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pin_change_detector uut (
    .clk        (clk),
    .rst        (rst),
    .pin_i      (pin),
    .dir_i      (dir),
    .rd_stb_i   (rd_stb),
    .wr_stb_i   (wr_stb),
    .clr_stb_i  (clr_stb),
    .chg_flag_o (flag)
  );

  task automatic step(input logic [7:0] p, input logic [7:0] d,
                      input logic rd, input logic wr, input logic clr);
    @(negedge clk);
    pin = p; dir = d; rd_stb = rd; wr_stb = wr; clr_stb = clr;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic exp, input string tag);
    n_cmp++;
    if (flag !== exp) begin
      n_bad++;
      $display("FAIL %s: flag=%0b expected=%0b (pin=%h dir=%h)", tag, flag, exp, pin, dir);
    end
  endtask

  task automatic do_reset(input logic [7:0] p);
    @(negedge clk);
    rst = 1'b1; pin = p; rd_stb = 1'b0; wr_stb = 1'b0; clr_stb = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk(1'b0, "R1 flag during reset");
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset loads reference from pins, flag clear
    do_reset(8'hA5);
    step(8'hA5, 8'hFF, 1'b0, 1'b0, 1'b0);
    chk(1'b0, "R1 idle after reset");
    step(8'hA5, 8'hFF, 1'b0, 1'b0, 1'b0);
    chk(1'b0, "R1 idle second cycle");

    // R3: only lower pins toggle
    for (int v = 0; v < 16; v++) begin
      step({4'hA, 4'(v)}, 8'hFF, 1'b0, 1'b0, 1'b0);
      chk(1'b0, "R3 lower pin change");
    end

    // Sweep: reference r, pins p, direction d on the watched nibble
    for (int r = 0; r < 16; r++) begin
      for (int p = 0; p < 16; p++) begin
        for (int d = 0; d < 16; d++) begin
          logic use_wr;
          logic exp;
          use_wr = 1'((r ^ p ^ d) & 1);
          exp = |(4'(p ^ r) & 4'(d));
          step({4'(r), 4'(p)}, 8'hFF, !use_wr, use_wr, 1'b0);
          step({4'(r), 4'(p)}, 8'hFF, 1'b0, 1'b0, 1'b1);
          chk(1'b0, use_wr ? "R7 clear after write reload" : "R6 clear after read reload");
          step({4'(p), 4'(p ^ d)}, {4'(d), 4'(~d)}, 1'b0, 1'b0, 1'b0);
          chk(exp, exp ? "R2 mismatch sets flag" : "R4 masked or equal pins");
          if (exp) begin
            step({4'(p), 4'(p ^ d)}, {4'(d), 4'(~d)}, 1'b0, 1'b0, 1'b1);
            chk(1'b1, "R5 set beats clear");
          end
          step({4'(r), 4'(d)}, {4'(d), 4'hF}, 1'b0, 1'b0, 1'b0);
          chk(exp, "R9 flag sticky after pins return");
          step({4'(r), 4'(d)}, {4'(d), 4'hF}, 1'b0, 1'b0, 1'b1);
          chk(1'b0, "R10 clear without mismatch");
        end
      end
    end

    // R8: a change arriving together with the access raises no flag
    step(8'h00, 8'hFF, 1'b1, 1'b0, 1'b0);
    step(8'h00, 8'hFF, 1'b0, 1'b0, 1'b1);
    chk(1'b0, "R8 setup clear");
    step(8'hF0, 8'hFF, 1'b1, 1'b0, 1'b0);
    chk(1'b0, "R8 access cycle blanks compare");
    step(8'hF0, 8'hFF, 1'b0, 1'b0, 1'b0);
    chk(1'b0, "R8 reference took new pins");
    step(8'h70, 8'hFF, 1'b0, 1'b0, 1'b0);
    chk(1'b1, "R2 later change flagged");
    step(8'h70, 8'hFF, 1'b0, 1'b1, 1'b0);
    chk(1'b1, "R8 access keeps set flag");

    // R1: reset while flag is set, with new pin values
    do_reset(8'h30);
    step(8'h30, 8'hFF, 1'b0, 1'b0, 1'b0);
    chk(1'b0, "R1 flag cleared and reference reloaded");
    step(8'h20, 8'hFF, 1'b0, 1'b0, 1'b0);
    chk(1'b1, "R1 reference equals pins at reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule